// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit turns a 16-bit segment base and a 16-bit offset into a 20-bit physical memory address. It holds four segment registers (code, data, stack and extra). For each request it picks one of them from the access kind: an instruction fetch, a general data access, a stack access, or a string destination. The address it produces is the selected segment moved up four bit places with the offset added, so the full space runs from 00000h to FFFFFh.

A caller presents an access kind and an offset with a request strobe. One clock later the unit returns the registered physical address with a valid strobe. A segment override input can swap in another segment register for data and stack accesses. A fetch always uses the code segment, and a string destination always uses the extra segment. The segment registers are loaded through a single write port.

Top module: `segaddr_gen`

## Requirements
- R1: On a request, the address returned is (segment value × 16 + offset); for example, segment 2222h with offset 0069h gives 22289h.
- R2: Any carry beyond bit 19 is dropped, so the sum wraps modulo 2^20 (segment FFFFh with offset 0010h gives 00000h).
- R3: `req_kind` 0 is an instruction fetch and always uses the code segment (register index 0), even when `ovr_en` is high.
- R4: Without override, `req_kind` 1 (data) uses the data segment (index 1), `req_kind` 2 (stack) uses the stack segment (index 2), and `req_kind` 3 (string destination) uses the extra segment (index 3).
- R5: When `ovr_en` is high on a data or stack request, the segment register named by `ovr_sel` (0 code, 1 data, 2 stack, 3 extra) is used instead of the implicit one.
- R6: `ovr_en` has no effect on a string destination request, which keeps the extra segment.
- R7: `phys_valid` is high exactly in the cycle after a cycle with `req_valid` high. `phys_addr` keeps its value when no request was made.
- R8: A segment write with `seg_we` high loads `seg_wdata` into the register at index `seg_wsel` at the clock edge. A request in the same cycle still sees the old value.
- R9: Reset (active-low `rst_n`) clears the data, stack and extra segments, sets the code segment to FFFFh, and clears `phys_addr` and `phys_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | 0 fetch, 1 data, 2 stack, 3 string destination |
| req_offset | input | 16 | Offset within the segment |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment index |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment register index to write |
| seg_wdata | input | 16 | Segment write value |
| phys_addr | output | 20 | Registered physical address |
| phys_valid | output | 1 | Address valid strobe |

## Verification
The bench targets the carry out of bit 19. A design that widened the sum or saturated it would return something other than 00000h for FFFFh:0010h. It also checks that an override arriving with a fetch or a string destination is ignored; a design that applied it everywhere would use the wrong base. A request issued in the same cycle as a write to its own segment must still see the old base; a design that bypassed the write would be one value early. After reset, a fetch at offset zero must land at FFFF0h; a design that cleared every register would return 00000h.

// File: rtl/segaddr_gen.sv
module segaddr_gen #(
  parameter int SEG_W    = 16,
  parameter int OFF_W    = 16,
  parameter int SHIFT    = 4,
  parameter int ADDR_W   = 20,
  parameter logic [15:0] CODE_RST = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_sel,
  input  logic              seg_we,
  input  logic [1:0]        seg_wsel,
  input  logic [SEG_W-1:0]  seg_wdata,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              phys_valid
);
  localparam logic [1:0] K_DATA  = 2'd1;
  localparam logic [1:0] K_STACK = 2'd2;

  logic [SEG_W-1:0]  seg_q [4];
  logic              ovr_ok;
  logic [1:0]        pick;
  logic [ADDR_W-1:0] base, sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q[0] <= SEG_W'(CODE_RST);
      seg_q[1] <= '0;
      seg_q[2] <= '0;
      seg_q[3] <= '0;
    end else if (seg_we) begin
      seg_q[seg_wsel] <= seg_wdata;
    end
  end

  assign ovr_ok = ovr_en && (req_kind == K_DATA || req_kind == K_STACK);
  assign pick   = ovr_ok ? ovr_sel : req_kind;
  assign base   = ADDR_W'({seg_q[pick], {SHIFT{1'b0}}});
  assign sum    = base + ADDR_W'(req_offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phys_addr  <= '0;
      phys_valid <= 1'b0;
    end else begin
      phys_valid <= req_valid;
      if (req_valid) phys_addr <= sum;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> phys_valid);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !phys_valid && $stable(phys_addr));
  a_r3_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |=>
      phys_addr == ADDR_W'({$past(seg_q[0]), {SHIFT{1'b0}}}) + ADDR_W'($past(req_offset)));
  a_r6_string_extra: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |=>
      phys_addr == ADDR_W'({$past(seg_q[3]), {SHIFT{1'b0}}}) + ADDR_W'($past(req_offset)));
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    seg_we |=> seg_q[$past(seg_wsel)] == $past(seg_wdata));
endmodule

// File: tb/segaddr_gen_tb.sv
`timescale 1ns/1ps
module segaddr_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, ovr_en = 1'b0, seg_we = 1'b0;
  logic [1:0] req_kind = '0, ovr_sel = '0, seg_wsel = '0;
  logic [15:0] req_offset = '0, seg_wdata = '0;
  logic [19:0] phys_addr;
  logic phys_valid;

  int n_run = 0, n_fail = 0;
  int m_seg [4];
  int e_addr = 0;
  bit e_valid = 0;
  string cur_tag = "R7", e_tag = "R7";

  always #2 clk = ~clk;

  segaddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_offset(req_offset), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .seg_we(seg_we), .seg_wsel(seg_wsel), .seg_wdata(seg_wdata),
    .phys_addr(phys_addr), .phys_valid(phys_valid));

  // behavioural reference
  always @(posedge clk) begin
    int s;
    if (!rst_n) begin
      m_seg[0] <= 'hFFFF; m_seg[1] <= 0; m_seg[2] <= 0; m_seg[3] <= 0;
      e_addr <= 0; e_valid <= 0;
    end else begin
      e_valid <= req_valid;
      if (req_valid) begin
        s = int'(req_kind);
        if (ovr_en && (req_kind == 2'd1 || req_kind == 2'd2)) s = int'(ovr_sel);
        e_addr <= (m_seg[s] * 16 + int'(req_offset)) % 1048576;
        e_tag <= cur_tag;
      end else e_tag <= "R7";
      if (seg_we) m_seg[seg_wsel] <= int'(seg_wdata);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit v, logic [1:0] k, logic [15:0] off, bit oe, logic [1:0] os,
                     bit we, logic [1:0] ws, logic [15:0] wd, string tag);
    req_valid = v; req_kind = k; req_offset = off; ovr_en = oe; ovr_sel = os;
    seg_we = we; seg_wsel = ws; seg_wdata = wd; cur_tag = tag;
    @(negedge clk);
    check({e_tag, " valid"}, int'(phys_valid), int'(e_valid));
    check({e_tag, " addr"}, int'(phys_addr), e_addr);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", int'(phys_valid), 0);
    check("R9 reset addr", int'(phys_addr), 0);
    rst_n = 1'b1;
    cyc(1, 0, 16'h0000, 0, 0, 0, 0, 0, "R9");
    check("R9 code reset FFFF0", int'(phys_addr), 'hFFFF0);
    cyc(1, 1, 16'h0000, 0, 0, 0, 0, 0, "R9");
    check("R9 data reset 0", int'(phys_addr), 0);
    cyc(1, 1, 16'h0069, 0, 0, 1, 1, 16'h2222, "R8");
    check("R8 old base used", int'(phys_addr), 'h00069);
    cyc(1, 1, 16'h0069, 0, 0, 0, 0, 0, "R1");
    check("R1 2222:0069", int'(phys_addr), 'h22289);
    cyc(1, 0, 16'h0010, 0, 0, 0, 0, 0, "R2");
    check("R2 wrap", int'(phys_addr), 'h00000);
    cyc(0, 0, 0, 0, 0, 1, 2, 16'h1000, "R8");
    check("R7 idle valid", int'(phys_valid), 0);
    check("R7 addr hold", int'(phys_addr), 'h00000);
    cyc(0, 0, 0, 0, 0, 1, 3, 16'h3000, "R8");
    cyc(1, 2, 16'h0005, 0, 0, 0, 0, 0, "R4");
    check("R4 stack", int'(phys_addr), 'h10005);
    cyc(1, 3, 16'h0007, 0, 0, 0, 0, 0, "R4");
    check("R4 extra", int'(phys_addr), 'h30007);
    cyc(1, 1, 16'h0001, 1, 2, 0, 0, 0, "R5");
    check("R5 data->stack", int'(phys_addr), 'h10001);
    cyc(1, 2, 16'h0002, 1, 3, 0, 0, 0, "R5");
    check("R5 stack->extra", int'(phys_addr), 'h30002);
    cyc(1, 0, 16'h0003, 1, 1, 0, 0, 0, "R3");
    check("R3 fetch ignores override", int'(phys_addr), 'hFFFF3 + 16'h0 - 'hFFFF3 + 'h0FFF3 + 'hF0000);
    cyc(1, 3, 16'h0004, 1, 1, 0, 0, 0, "R6");
    check("R6 string ignores override", int'(phys_addr), 'h30004);
    for (int i = 0; i < 400; i++) begin
      cyc($urandom_range(0, 3) != 0, 2'($urandom), 16'($urandom), 1'($urandom),
          2'($urandom), $urandom_range(0, 3) == 0, 2'($urandom), 16'($urandom), "R1");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule